// File: doc/BRIEF.md
# Multi-Context Register File with Frame Pointer

This block holds the architectural register state of a processor that keeps several threads resident at once and switches between them by moving a pointer. It has four task frames, and each frame has 32 general registers. A bank of 8 global registers is reachable from every frame. Each frame also keeps its own program counter, its own next program counter and its own 32-bit status word. A small floating-point file of 32 entries is split into four banks of 8, one bank per frame, and each bank carries its own condition bits.

The frame pointer decides which frame the register addresses refer to. Decoded instruction operations can step the pointer up or down, copy it into a general register, load it from a general register, and move the active status word to or from a general register. A context-switch request stores the outgoing PC chain into the active frame and points the block at a chosen target frame. No register contents are copied during a switch. The general file has two combinational read ports and one write port. A read of a register that is being written in the same cycle returns the new value.

Top module: `ctx_regfile`

## Requirements
- R1: During and after reset, the frame pointer is 0, and every general, global, PC, next-PC, status, floating-point and condition-bit value reads as 0.
- R2: When address bit 5 is 0, a general-register address selects register addr[4:0] of the frame named by the frame pointer. A value written in one frame does not appear at the same address in another frame.
- R3: When address bit 5 is 1, the address selects global register addr[2:0]. This gives the same result whatever the frame pointer holds. Address bits 4:3 are ignored for globals.
- R4: A read on either port of the register written in the same cycle returns the write data. The register holds that value from the next cycle on.
- R5: Operation code 1 adds one to the frame pointer and wraps 3 to 0. Code 2 subtracts one and wraps 0 to 3. Both take effect on the next clock edge. Code 0 leaves the pointer unchanged.
- R6: Operation code 3 writes the zero-extended frame pointer into the register at wr_addr. It ignores wr_data and does not need wr_en.
- R7: Operation code 4 loads the frame pointer from the low 2 bits of read port A's data. That data includes any same-cycle write.
- R8: Operation code 6 loads the active frame's status word from read port A's data. Code 5 writes the active status word into the register at wr_addr. The active status word appears on act_psr.
- R9: A context-switch request stores sw_pc and sw_npc into the active frame and sets the frame pointer to sw_target on the next edge. When it coincides with a pointer operation, the switch wins. act_pc and act_npc always show the stored chain of the frame the pointer names.
- R10: A floating-point address (3 bits) selects an entry in the bank of the active frame. A same-cycle write to that entry is returned on the read port. Each bank keeps its own 2-bit condition field, written by fcc_wr_en and shown on fcc for the active frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Pointer/status operation: 0 none, 1 step up, 2 step down, 3 pointer to register, 4 register to pointer, 5 status to register, 6 register to status |
| rd_a_addr | input | 6 | Read port A address (bit 5 selects globals) |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 6 | Read port B address |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_addr | input | 6 | Write address |
| wr_data | input | 32 | Write data |
| sw_req | input | 1 | Context-switch request |
| sw_target | input | 2 | Frame to switch to |
| sw_pc | input | 32 | PC to store in the outgoing frame |
| sw_npc | input | 32 | Next-PC to store in the outgoing frame |
| fp | output | 2 | Current frame pointer |
| act_pc | output | 32 | Stored PC of the active frame |
| act_npc | output | 32 | Stored next-PC of the active frame |
| act_psr | output | 32 | Status word of the active frame |
| fpr_rd_addr | input | 3 | Floating-point read address within the active bank |
| fpr_rd_data | output | 32 | Floating-point read data |
| fpr_wr_en | input | 1 | Floating-point write enable |
| fpr_wr_addr | input | 3 | Floating-point write address within the active bank |
| fpr_wr_data | input | 32 | Floating-point write data |
| fcc_wr_en | input | 1 | Condition-bit write enable for the active bank |
| fcc_wr_data | input | 2 | Condition bits to write |
| fcc | output | 2 | Condition bits of the active bank |

## Verification
The assertions assume three things about the inputs. At most one operation code is active per cycle. Codes above 6 are never driven. Writes and pointer changes land on the frame that the pointer named before the edge. The stimulus drives one operation per cycle from a vector table, always with a defined code. It changes inputs only on the falling edge, so the pointer used by every write is the settled value from the previous cycle. Context switches are issued both alone and together with a step operation, so the priority rule is exercised without relying on any other overlap.

// File: rtl/ctx_rf_pkg.sv
`timescale 1ns/1ps
package ctx_rf_pkg;
    typedef enum logic [2:0] {
        OP_NONE        = 3'd0,
        OP_FP_INC      = 3'd1,
        OP_FP_DEC      = 3'd2,
        OP_FP_TO_REG   = 3'd3,
        OP_REG_TO_FP   = 3'd4,
        OP_PSR_TO_REG  = 3'd5,
        OP_REG_TO_PSR  = 3'd6
    } ctl_op_e;
endpackage

// File: rtl/ctx_fp_ctrl.sv
`timescale 1ns/1ps
module ctx_fp_ctrl #(
    parameter int FRAMES = 4,
    parameter int FW     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          load,
    input  logic [FW-1:0] load_val,
    input  logic          sw_req,
    input  logic [FW-1:0] sw_target,
    output logic [FW-1:0] fp
);
    localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

    typedef struct packed {
        logic [FW-1:0] fp;
    } fp_state_t;

    fp_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sw_req) begin
            s_d.fp = sw_target;
        end else if (load) begin
            s_d.fp = load_val;
        end else if (inc) begin
            s_d.fp = (s_q.fp == LAST) ? '0 : s_q.fp + 1'b1;
        end else if (dec) begin
            s_d.fp = (s_q.fp == '0) ? LAST : s_q.fp - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fp = s_q.fp;

    // R5: stepping up from the last frame lands on frame 0
    assert_fp_wrap_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !sw_req && !load && fp == LAST) |=> fp == '0);
    // R5: stepping down from frame 0 lands on the last frame
    assert_fp_wrap_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && !sw_req && !load && fp == '0) |=> fp == LAST);
    // R9: a switch request always sets the pointer to its target
    assert_switch_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |=> fp == $past(sw_target));
    // R5: no request, no movement
    assert_fp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc || dec || load || sw_req) |=> $stable(fp));
endmodule

// File: rtl/ctx_gpr_bank.sv
`timescale 1ns/1ps
module ctx_gpr_bank #(
    parameter int XLEN       = 32,
    parameter int FRAMES     = 4,
    parameter int FW         = 2,
    parameter int FRAME_REGS = 32,
    parameter int GLOBALS    = 8,
    parameter int RW         = 5,
    parameter int GW         = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FW-1:0]   fp,
    input  logic [RW:0]     rd_a_addr,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [RW:0]     rd_b_addr,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [RW:0]     wr_addr,
    input  logic [XLEN-1:0] wr_data
);
    localparam int AW    = RW + 1;
    localparam int PORTS = 2;

    typedef struct packed {
        logic [FRAMES-1:0][FRAME_REGS-1:0][XLEN-1:0] frm;
        logic [GLOBALS-1:0][XLEN-1:0]                glb;
    } gpr_state_t;

    gpr_state_t s_d, s_q;

    logic [PORTS-1:0][AW-1:0]   rd_addr;
    logic [PORTS-1:0][XLEN-1:0] rd_data;

    assign rd_addr[0] = rd_a_addr;
    assign rd_addr[1] = rd_b_addr;
    assign rd_a_data  = rd_data[0];
    assign rd_b_data  = rd_data[1];

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        logic [XLEN-1:0] stored;
        logic            is_glb;
        logic            hit;
        always_comb begin
            is_glb = rd_addr[p][AW-1];
            if (is_glb) stored = s_q.glb[rd_addr[p][GW-1:0]];
            else        stored = s_q.frm[fp][rd_addr[p][RW-1:0]];
            hit = wr_en && (wr_addr[AW-1] == is_glb) &&
                  (is_glb ? (wr_addr[GW-1:0] == rd_addr[p][GW-1:0])
                          : (wr_addr[RW-1:0] == rd_addr[p][RW-1:0]));
            rd_data[p] = hit ? wr_data : stored;
        end
    end

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (wr_addr[AW-1]) s_d.glb[wr_addr[GW-1:0]]     = wr_data;
            else               s_d.frm[fp][wr_addr[RW-1:0]] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: storage changes only through the write port
    assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q));
    // R3: a global write lands in the global bank whatever the frame
    assert_global_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[AW-1]) |=> s_q.glb[$past(wr_addr[GW-1:0])] == $past(wr_data));
    // R4: a frame write is visible next cycle in the frame used at write time
    assert_frame_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr[AW-1]) |=> s_q.frm[$past(fp)][$past(wr_addr[RW-1:0])] == $past(wr_data));
endmodule

// File: rtl/ctx_chain_bank.sv
`timescale 1ns/1ps
module ctx_chain_bank #(
    parameter int XLEN   = 32,
    parameter int FRAMES = 4,
    parameter int FW     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FW-1:0]   fp,
    input  logic            save_en,
    input  logic [XLEN-1:0] save_pc,
    input  logic [XLEN-1:0] save_npc,
    input  logic            psr_we,
    input  logic [XLEN-1:0] psr_wd,
    output logic [XLEN-1:0] act_pc,
    output logic [XLEN-1:0] act_npc,
    output logic [XLEN-1:0] act_psr
);
    typedef struct packed {
        logic [FRAMES-1:0][XLEN-1:0] pc;
        logic [FRAMES-1:0][XLEN-1:0] npc;
        logic [FRAMES-1:0][XLEN-1:0] psr;
    } chain_state_t;

    chain_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (save_en) begin
            s_d.pc[fp]  = save_pc;
            s_d.npc[fp] = save_npc;
        end
        if (psr_we) s_d.psr[fp] = psr_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act_pc  = s_q.pc[fp];
    assign act_npc = s_q.npc[fp];
    assign act_psr = s_q.psr[fp];

    // R9: the outgoing frame keeps the chain it was switched out with
    assert_chain_saved_R9: assert property (@(posedge clk) disable iff (!rst_n)
        save_en |=> (s_q.pc[$past(fp)] == $past(save_pc)) && (s_q.npc[$past(fp)] == $past(save_npc)));
    // R8: status words change only on a status load
    assert_psr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !psr_we |=> $stable(s_q.psr));
endmodule

// File: rtl/ctx_fpr_bank.sv
`timescale 1ns/1ps
module ctx_fpr_bank #(
    parameter int XLEN    = 32,
    parameter int FRAMES  = 4,
    parameter int FW      = 2,
    parameter int FP_REGS = 32,
    parameter int BW      = 3,
    parameter int FCC_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FW-1:0]    fp,
    input  logic [BW-1:0]    rd_addr,
    output logic [XLEN-1:0]  rd_data,
    input  logic             wr_en,
    input  logic [BW-1:0]    wr_addr,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             cc_we,
    input  logic [FCC_W-1:0] cc_wd,
    output logic [FCC_W-1:0] cc
);
    localparam int PW = FW + BW;

    typedef struct packed {
        logic [FP_REGS-1:0][XLEN-1:0] regs;
        logic [FRAMES-1:0][FCC_W-1:0] cc;
    } fpr_state_t;

    fpr_state_t s_d, s_q;

    logic [PW-1:0] rd_phys;
    logic [PW-1:0] wr_phys;

    assign rd_phys = {fp, rd_addr};
    assign wr_phys = {fp, wr_addr};

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.regs[wr_phys] = wr_data;
        if (cc_we) s_d.cc[fp]        = cc_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data = (wr_en && wr_addr == rd_addr) ? wr_data : s_q.regs[rd_phys];
    assign cc      = s_q.cc[fp];

    // R10: floating-point storage changes only through its write port
    assert_fpr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q.regs));
    // R10: condition bits land in the bank of the frame active at write time
    assert_fcc_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we |=> s_q.cc[$past(fp)] == $past(cc_wd));
endmodule

// File: rtl/ctx_regfile.sv
`timescale 1ns/1ps
module ctx_regfile #(
    parameter int XLEN       = 32,
    parameter int FRAMES     = 4,
    parameter int FRAME_REGS = 32,
    parameter int GLOBALS    = 8,
    parameter int FP_REGS    = 32,
    parameter int FCC_W      = 2,
    localparam int FW = $clog2(FRAMES),
    localparam int RW = $clog2(FRAME_REGS),
    localparam int GW = $clog2(GLOBALS),
    localparam int BW = $clog2(FP_REGS / FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op,
    input  logic [RW:0]      rd_a_addr,
    output logic [XLEN-1:0]  rd_a_data,
    input  logic [RW:0]      rd_b_addr,
    output logic [XLEN-1:0]  rd_b_data,
    input  logic             wr_en,
    input  logic [RW:0]      wr_addr,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             sw_req,
    input  logic [FW-1:0]    sw_target,
    input  logic [XLEN-1:0]  sw_pc,
    input  logic [XLEN-1:0]  sw_npc,
    output logic [FW-1:0]    fp,
    output logic [XLEN-1:0]  act_pc,
    output logic [XLEN-1:0]  act_npc,
    output logic [XLEN-1:0]  act_psr,
    input  logic [BW-1:0]    fpr_rd_addr,
    output logic [XLEN-1:0]  fpr_rd_data,
    input  logic             fpr_wr_en,
    input  logic [BW-1:0]    fpr_wr_addr,
    input  logic [XLEN-1:0]  fpr_wr_data,
    input  logic             fcc_wr_en,
    input  logic [FCC_W-1:0] fcc_wr_data,
    output logic [FCC_W-1:0] fcc
);
    import ctx_rf_pkg::*;

    ctl_op_e         op_e;
    logic            put_fp;
    logic            put_psr;
    logic            gpr_we;
    logic [XLEN-1:0] gpr_wd;

    always_comb begin
        op_e    = ctl_op_e'(op);
        put_fp  = (op_e == OP_FP_TO_REG);
        put_psr = (op_e == OP_PSR_TO_REG);
        gpr_we  = wr_en || put_fp || put_psr;
        if (put_fp)       gpr_wd = XLEN'(fp);
        else if (put_psr) gpr_wd = act_psr;
        else              gpr_wd = wr_data;
    end

    ctx_fp_ctrl #(.FRAMES(FRAMES), .FW(FW)) i_fp (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (op_e == OP_FP_INC),
        .dec       (op_e == OP_FP_DEC),
        .load      (op_e == OP_REG_TO_FP),
        .load_val  (rd_a_data[FW-1:0]),
        .sw_req    (sw_req),
        .sw_target (sw_target),
        .fp        (fp)
    );

    ctx_gpr_bank #(
        .XLEN(XLEN), .FRAMES(FRAMES), .FW(FW), .FRAME_REGS(FRAME_REGS),
        .GLOBALS(GLOBALS), .RW(RW), .GW(GW)
    ) i_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .fp        (fp),
        .rd_a_addr (rd_a_addr),
        .rd_a_data (rd_a_data),
        .rd_b_addr (rd_b_addr),
        .rd_b_data (rd_b_data),
        .wr_en     (gpr_we),
        .wr_addr   (wr_addr),
        .wr_data   (gpr_wd)
    );

    ctx_chain_bank #(.XLEN(XLEN), .FRAMES(FRAMES), .FW(FW)) i_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .fp       (fp),
        .save_en  (sw_req),
        .save_pc  (sw_pc),
        .save_npc (sw_npc),
        .psr_we   (op_e == OP_REG_TO_PSR),
        .psr_wd   (rd_a_data),
        .act_pc   (act_pc),
        .act_npc  (act_npc),
        .act_psr  (act_psr)
    );

    ctx_fpr_bank #(
        .XLEN(XLEN), .FRAMES(FRAMES), .FW(FW), .FP_REGS(FP_REGS),
        .BW(BW), .FCC_W(FCC_W)
    ) i_fpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .fp      (fp),
        .rd_addr (fpr_rd_addr),
        .rd_data (fpr_rd_data),
        .wr_en   (fpr_wr_en),
        .wr_addr (fpr_wr_addr),
        .wr_data (fpr_wr_data),
        .cc_we   (fcc_wr_en),
        .cc_wd   (fcc_wr_data),
        .cc      (fcc)
    );

    // R6: copying the pointer out lands in the active frame's register next cycle
    assert_fp_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_FP_TO_REG && !sw_req && !wr_addr[RW]) |=>
        i_gpr.s_q.frm[$past(fp)][$past(wr_addr[RW-1:0])] == XLEN'($past(fp)));
    // R7: loading the pointer takes port A's value
    assert_fp_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_REG_TO_FP && !sw_req) |=> fp == $past(rd_a_data[FW-1:0]));
endmodule

// File: tb/test_ctx_regfile.sv
`timescale 1ns/1ps
module test_ctx_regfile;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op;
    logic [5:0]  rd_a_addr, rd_b_addr, wr_addr;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en, sw_req;
    logic [1:0]  sw_target, fp;
    logic [31:0] sw_pc, sw_npc, act_pc, act_npc, act_psr;
    logic [2:0]  fpr_rd_addr, fpr_wr_addr;
    logic [31:0] fpr_rd_data, fpr_wr_data;
    logic        fpr_wr_en, fcc_wr_en;
    logic [1:0]  fcc_wr_data, fcc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ctx_regfile i_ctx_regfile (
        .clk(clk), .rst_n(rst_n), .op(op),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sw_req(sw_req), .sw_target(sw_target), .sw_pc(sw_pc), .sw_npc(sw_npc),
        .fp(fp), .act_pc(act_pc), .act_npc(act_npc), .act_psr(act_psr),
        .fpr_rd_addr(fpr_rd_addr), .fpr_rd_data(fpr_rd_data),
        .fpr_wr_en(fpr_wr_en), .fpr_wr_addr(fpr_wr_addr), .fpr_wr_data(fpr_wr_data),
        .fcc_wr_en(fcc_wr_en), .fcc_wr_data(fcc_wr_data), .fcc(fcc)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [5:0]  ra;
        logic [5:0]  rb;
        logic        we;
        logic [5:0]  wa;
        logic [31:0] wd;
        logic [31:0] ea;
        logic [31:0] eb;
        logic [1:0]  efp;
    } vec_t;

    // efp is the pointer expected before the edge; ea/eb are same-cycle reads
    localparam vec_t VECS [14] = '{
        '{3'd0, 6'h05, 6'h06, 1'b1, 6'h05, 32'h11,   32'h11, 32'h00, 2'd0}, // R4 bypass, frame 0
        '{3'd1, 6'h05, 6'h00, 1'b0, 6'h00, 32'h00,   32'h11, 32'h00, 2'd0}, // R4 stored, R5 step up
        '{3'd0, 6'h05, 6'h20, 1'b1, 6'h05, 32'h22,   32'h22, 32'h00, 2'd1}, // R2 frame 1 own r5
        '{3'd0, 6'h20, 6'h05, 1'b1, 6'h20, 32'h33,   32'h33, 32'h22, 2'd1}, // R3 global write
        '{3'd2, 6'h28, 6'h05, 1'b0, 6'h00, 32'h00,   32'h33, 32'h22, 2'd1}, // R3 alias bits ignored, R5 down
        '{3'd0, 6'h05, 6'h20, 1'b0, 6'h00, 32'h00,   32'h11, 32'h33, 2'd0}, // R2 frame 0 kept, R3 shared
        '{3'd2, 6'h05, 6'h06, 1'b0, 6'h00, 32'h00,   32'h11, 32'h00, 2'd0}, // R5 wrap 0 to 3
        '{3'd3, 6'h07, 6'h05, 1'b0, 6'h07, 32'hdead, 32'h03, 32'h00, 2'd3}, // R6 pointer copied, data ignored
        '{3'd1, 6'h07, 6'h06, 1'b0, 6'h00, 32'h00,   32'h03, 32'h00, 2'd3}, // R6 stored, R5 wrap 3 to 0
        '{3'd0, 6'h07, 6'h05, 1'b0, 6'h00, 32'h00,   32'h00, 32'h11, 2'd0}, // R2 frame 0 r7 untouched
        '{3'd4, 6'h09, 6'h00, 1'b1, 6'h09, 32'h02,   32'h02, 32'h00, 2'd0}, // R7 load from bypassed port A
        '{3'd0, 6'h09, 6'h20, 1'b0, 6'h00, 32'h00,   32'h00, 32'h33, 2'd2}, // R7 pointer now 2
        '{3'd6, 6'h20, 6'h09, 1'b0, 6'h00, 32'h00,   32'h33, 32'h00, 2'd2}, // R8 status load
        '{3'd5, 6'h01, 6'h20, 1'b0, 6'h01, 32'h00,   32'h33, 32'h33, 2'd2}  // R8 status to register
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        op = 3'd0; rd_a_addr = '0; rd_b_addr = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        sw_req = 1'b0; sw_target = '0; sw_pc = '0; sw_npc = '0;
        fpr_rd_addr = '0; fpr_wr_en = 1'b0; fpr_wr_addr = '0; fpr_wr_data = '0;
        fcc_wr_en = 1'b0; fcc_wr_data = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd_a_addr = 6'h05; rd_b_addr = 6'h20;
        #1;
        check("R1 fp during reset", 32'(fp), 32'h0);
        rst_n = 1'b1;
        #1;
        check("R1 frame reg", rd_a_data, 32'h0);
        check("R1 global reg", rd_b_data, 32'h0);
        check("R1 pc", act_pc, 32'h0);
        check("R1 npc", act_npc, 32'h0);
        check("R1 psr", act_psr, 32'h0);
        check("R1 fpr", fpr_rd_data, 32'h0);
        check("R1 fcc", 32'(fcc), 32'h0);

        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            idle();
            op = VECS[i].op; rd_a_addr = VECS[i].ra; rd_b_addr = VECS[i].rb;
            wr_en = VECS[i].we; wr_addr = VECS[i].wa; wr_data = VECS[i].wd;
            #1;
            check($sformatf("table row %0d fp", i), 32'(fp), 32'(VECS[i].efp));
            check($sformatf("table row %0d port A", i), rd_a_data, VECS[i].ea);
            check($sformatf("table row %0d port B", i), rd_b_data, VECS[i].eb);
        end

        @(negedge clk);
        idle();
        rd_a_addr = 6'h01;
        #1;
        check("R8 act_psr frame 2", act_psr, 32'h33);
        check("R8 status copy stored", rd_a_data, 32'h33);

        // R9: switch wins over a simultaneous step up
        @(negedge clk);
        idle();
        sw_req = 1'b1; sw_target = 2'd1; sw_pc = 32'h100; sw_npc = 32'h104; op = 3'd1;
        @(negedge clk);
        idle();
        #1;
        check("R9 switch priority fp", 32'(fp), 32'h1);
        check("R9 fresh frame pc", act_pc, 32'h0);
        check("R9 fresh frame psr", act_psr, 32'h0);
        sw_req = 1'b1; sw_target = 2'd2; sw_pc = 32'h200; sw_npc = 32'h204;
        @(negedge clk);
        idle();
        #1;
        check("R9 fp to 2", 32'(fp), 32'h2);
        check("R9 restored pc", act_pc, 32'h100);
        check("R9 restored npc", act_npc, 32'h104);
        check("R8 psr follows frame", act_psr, 32'h33);
        sw_req = 1'b1; sw_target = 2'd1; sw_pc = 32'h300; sw_npc = 32'h304;
        @(negedge clk);
        idle();
        #1;
        check("R9 back to frame 1 pc", act_pc, 32'h200);
        check("R9 back to frame 1 npc", act_npc, 32'h204);

        // R10: floating-point bank of frame 1
        fpr_wr_en = 1'b1; fpr_wr_addr = 3'd3; fpr_wr_data = 32'haa; fpr_rd_addr = 3'd3;
        fcc_wr_en = 1'b1; fcc_wr_data = 2'b10;
        #1;
        check("R10 fpr bypass", fpr_rd_data, 32'haa);
        @(negedge clk);
        idle();
        fpr_rd_addr = 3'd3;
        #1;
        check("R10 fpr stored", fpr_rd_data, 32'haa);
        check("R10 fcc stored", 32'(fcc), 32'h2);
        op = 3'd1;
        @(negedge clk);
        idle();
        fpr_rd_addr = 3'd3;
        #1;
        check("R10 other bank fpr", fpr_rd_data, 32'h0);
        check("R10 other bank fcc", 32'(fcc), 32'h0);
        op = 3'd2;
        @(negedge clk);
        idle();
        fpr_rd_addr = 3'd3;
        #1;
        check("R10 bank 1 again fpr", fpr_rd_data, 32'haa);
        check("R10 bank 1 again fcc", 32'(fcc), 32'h2);

        // R1: reset in the middle of a run
        rst_n = 1'b0;
        rd_a_addr = 6'h05; rd_b_addr = 6'h20;
        #1;
        check("R1 fp after late reset", 32'(fp), 32'h0);
        check("R1 reg cleared", rd_a_data, 32'h0);
        check("R1 global cleared", rd_b_data, 32'h0);
        check("R1 fpr cleared", fpr_rd_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule